// File: doc/BRIEF.md
# Capped Even Core Partitioner

This block divides a fixed pool of compute cores among one to four applications that share the device at the same time. A start pulse captures how many applications are active and how many independent work groups each one can issue. From those values the block works out how many cores each application gets and which application owns each core. The split is as even as the pool allows. No application is given more cores than it has work groups, because a single work group never spans two cores. Cores that a capped application cannot use go back into the pool for the others.

Cores are handed out one per cycle in round-robin order over the active applications. The scan skips any application that has reached its work-group count. It stops when the pool is empty or when a full round grants nothing. The owner map lists the applications in contiguous ascending core ranges. Cores that nobody can use are marked idle. The result stays frozen, with done high, until the next start pulse. The inputs only matter in the cycle of that pulse.

Top module: `cpart_top`

## Requirements
- R1: After a start pulse, done is low on the next cycle and rises once the allocation is complete. It stays high until the next start pulse. A start pulse during an allocation abandons it and begins again with the new inputs.
- R2: Among active applications that end below their work-group count, core counts differ by at most one.
- R3: No application's core count exceeds the work-group count captured for it at start.
- R4: When the pool does not divide evenly, the extra cores go to the lowest-numbered eligible applications first. For example, four uncapped applications on 30 cores get 8, 8, 7, 7.
- R5: Cores that a capped application gives up go to the other applications. The total assigned equals the smaller of the pool size and the sum of the active work-group counts. Any cores left over are idle.
- R6: Each owner-map entry is 3 bits wide. Bit 2 is valid and bits 1:0 are the application ID; an idle core reads 0. Core n is entry bits [3n+2:3n]. Owned cores form contiguous ranges in ascending application order, starting at core 0.
- R7: If the application count is 0 or greater than 4, err is set, every core count is 0, every map entry is idle, and done still rises.
- R8: While done is high and no start arrives, changes on num_apps and wg_count have no effect. err, the core counts and the owner map stay unchanged.
- R9: Application slots with an index at or above the active count get 0 cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; captures the inputs and begins an allocation |
| num_apps | input | 3 | Number of active applications (valid range 1..4) |
| wg_count | input | 32 | Work-group count per application, 8 bits each; application k at bits [8k+7:8k] |
| done | output | 1 | Allocation complete and outputs stable |
| err | output | 1 | Application count out of range |
| core_cnt | output | 20 | Cores per application, 5 bits each; application k at bits [5k+4:5k] |
| owner_map | output | 90 | Per-core owner entry, 3 bits each (see R6) |

## Verification
Two events can land in the same cycle: the grant of the last core in the pool, and the scan wrapping past the last active application. A separate coincidence is a round that grants nothing while that wrap happens. The first is provoked by configurations where the pool is used up exactly on the highest active application, such as three uncapped applications on 30 cores. The second is provoked by caps whose sum is below the pool. In both cases the bench compares each core count and the whole owner map with a water-fill result it computes arithmetically. It also confirms that done rose and that the outputs then hold while the inputs are disturbed.

// File: rtl/cpart_pkg.sv
package cpart_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } cp_state_e;
endpackage

// File: rtl/cpart_alloc.sv
module cpart_alloc
  import cpart_pkg::*;
#(
  parameter int NUM_CORES = 30,
  parameter int MAX_APPS  = 4,
  parameter int WG_W      = 8,
  parameter int CNT_W     = $clog2(NUM_CORES + 1),
  parameter int NA_W      = $clog2(MAX_APPS) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NA_W-1:0]           num_apps,
  input  logic [MAX_APPS*WG_W-1:0]  wg_flat,
  output logic                      done_o,
  output logic                      err_o,
  output logic [MAX_APPS*CNT_W-1:0] cnt_flat,
  output logic [MAX_APPS*WG_W-1:0]  cap_flat
);
  localparam int PTR_W = (MAX_APPS > 1) ? $clog2(MAX_APPS) : 1;
  localparam int CMP_W = (WG_W > CNT_W) ? WG_W : CNT_W;

  cp_state_e        state_q;
  logic [WG_W-1:0]  cap_q [MAX_APPS];
  logic [CNT_W-1:0] cnt_q [MAX_APPS];
  logic [CNT_W-1:0] rem_q;
  logic [PTR_W-1:0] ptr_q;
  logic [NA_W-1:0]  n_q;
  logic             granted_q;
  logic             err_q;

  logic bad_req, give, at_last, pool_last;

  assign bad_req   = (num_apps == '0) || (num_apps > NA_W'(MAX_APPS));
  assign give      = (state_q == ST_RUN) && (rem_q != '0) &&
                     (CMP_W'(cnt_q[ptr_q]) < CMP_W'(cap_q[ptr_q]));
  assign at_last   = (NA_W'(ptr_q) == (n_q - NA_W'(1)));
  assign pool_last = (rem_q == '0) || (give && (rem_q == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      ptr_q     <= '0;
      n_q       <= '0;
      granted_q <= 1'b0;
      err_q     <= 1'b0;
      for (int i = 0; i < MAX_APPS; i++) begin
        cap_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (start) begin
      state_q   <= ST_RUN;
      n_q       <= num_apps;
      ptr_q     <= '0;
      granted_q <= 1'b0;
      err_q     <= bad_req;
      rem_q     <= bad_req ? '0 : CNT_W'(NUM_CORES);
      for (int i = 0; i < MAX_APPS; i++) begin
        cap_q[i] <= (i < int'(num_apps)) ? wg_flat[i*WG_W +: WG_W] : '0;
        cnt_q[i] <= '0;
      end
    end else if (state_q == ST_RUN) begin
      if (give) begin
        cnt_q[ptr_q] <= cnt_q[ptr_q] + CNT_W'(1);
        rem_q        <= rem_q - CNT_W'(1);
      end
      if (pool_last) begin
        state_q <= ST_DONE;
      end else if (at_last) begin
        if (!(granted_q || give)) begin
          state_q <= ST_DONE;
        end else begin
          ptr_q     <= '0;
          granted_q <= 1'b0;
        end
      end else begin
        ptr_q     <= ptr_q + PTR_W'(1);
        granted_q <= granted_q | give;
      end
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;

  for (genvar g = 0; g < MAX_APPS; g++) begin : g_out
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
    assign cap_flat[g*WG_W +: WG_W]   = cap_q[g];
  end
endmodule

// File: rtl/cpart_map.sv
module cpart_map #(
  parameter int NUM_CORES = 30,
  parameter int MAX_APPS  = 4,
  parameter int CNT_W     = $clog2(NUM_CORES + 1),
  parameter int ID_W      = (MAX_APPS > 1) ? $clog2(MAX_APPS) : 1,
  parameter int ENT_W     = ID_W + 1
) (
  input  logic [MAX_APPS*CNT_W-1:0]  cnt_flat,
  output logic [NUM_CORES*ENT_W-1:0] map_flat
);
  localparam int SUM_W = CNT_W + ID_W + 1;

  logic [SUM_W-1:0] pre [MAX_APPS+1];

  always_comb begin
    pre[0] = '0;
    for (int i = 0; i < MAX_APPS; i++) begin
      pre[i+1] = pre[i] + SUM_W'(cnt_flat[i*CNT_W +: CNT_W]);
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [ID_W-1:0] id;
    logic            owned;
    always_comb begin
      id = '0;
      for (int i = 1; i < MAX_APPS; i++) begin
        if (pre[i] <= SUM_W'(c)) id = id + ID_W'(1);
      end
    end
    assign owned = (SUM_W'(c) < pre[MAX_APPS]);
    assign map_flat[c*ENT_W +: ENT_W] = owned ? {1'b1, id} : '0;
  end
endmodule

// File: rtl/cpart_top.sv
module cpart_top #(
  parameter int NUM_CORES = 30,
  parameter int MAX_APPS  = 4,
  parameter int WG_W      = 8,
  parameter int CNT_W     = $clog2(NUM_CORES + 1),
  parameter int NA_W      = $clog2(MAX_APPS) + 1,
  parameter int ENT_W     = ((MAX_APPS > 1) ? $clog2(MAX_APPS) : 1) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NA_W-1:0]            num_apps,
  input  logic [MAX_APPS*WG_W-1:0]   wg_count,
  output logic                       done,
  output logic                       err,
  output logic [MAX_APPS*CNT_W-1:0]  core_cnt,
  output logic [NUM_CORES*ENT_W-1:0] owner_map
);
  logic [MAX_APPS*WG_W-1:0] cap_flat;

  cpart_alloc #(
    .NUM_CORES(NUM_CORES), .MAX_APPS(MAX_APPS), .WG_W(WG_W),
    .CNT_W(CNT_W), .NA_W(NA_W)
  ) u_alloc (
    .clk(clk), .rst_n(rst_n), .start(start), .num_apps(num_apps),
    .wg_flat(wg_count), .done_o(done), .err_o(err),
    .cnt_flat(core_cnt), .cap_flat(cap_flat)
  );

  cpart_map #(
    .NUM_CORES(NUM_CORES), .MAX_APPS(MAX_APPS), .CNT_W(CNT_W),
    .ENT_W(ENT_W)
  ) u_map (
    .cnt_flat(core_cnt), .map_flat(owner_map)
  );
endmodule

// File: rtl/cpart_chk.sv
module cpart_chk #(
  parameter int NUM_CORES = 30,
  parameter int MAX_APPS  = 4,
  parameter int WG_W      = 8,
  parameter int CNT_W     = 5,
  parameter int ENT_W     = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       done,
  input logic                       err,
  input logic [MAX_APPS*CNT_W-1:0]  core_cnt,
  input logic [MAX_APPS*WG_W-1:0]   cap_flat,
  input logic [NUM_CORES*ENT_W-1:0] owner_map
);
  localparam int CMP_W = ((WG_W > CNT_W) ? WG_W : CNT_W) + 1;
  localparam int SUM_W = CNT_W + 4;

  logic [SUM_W-1:0]     total;
  logic [NUM_CORES-1:0] vld;

  always_comb begin
    total = '0;
    for (int i = 0; i < MAX_APPS; i++) total = total + SUM_W'(core_cnt[i*CNT_W +: CNT_W]);
  end
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_v
    assign vld[c] = owner_map[c*ENT_W + ENT_W - 1];
  end

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R1
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(core_cnt) && $stable(owner_map) && $stable(err))); // R8
  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (total <= SUM_W'(NUM_CORES))); // R5
  AST_MAP_MATCHES_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(vld) == int'(total))); // R6
  AST_ERR_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (core_cnt == '0 && vld == '0)); // R7

  for (genvar i = 0; i < MAX_APPS; i++) begin : g_i
    logic [CMP_W-1:0] ci, ki;
    assign ci = CMP_W'(core_cnt[i*CNT_W +: CNT_W]);
    assign ki = CMP_W'(cap_flat[i*WG_W +: WG_W]);
    AST_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ci <= ki)); // R3
    for (genvar j = 0; j < MAX_APPS; j++) begin : g_j
      logic [CMP_W-1:0] cj, kj;
      assign cj = CMP_W'(core_cnt[j*CNT_W +: CNT_W]);
      assign kj = CMP_W'(cap_flat[j*WG_W +: WG_W]);
      if (i != j) begin : g_pair
        AST_NEAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
          (done && !err) |-> ((ci + CMP_W'(1) >= cj) || (ci == ki))); // R2
      end
      if (i < j) begin : g_ord
        AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
          (done && !err && ci < ki && cj < kj) |-> (ci >= cj)); // R4
      end
    end
  end
endmodule

bind cpart_top cpart_chk #(
  .NUM_CORES(NUM_CORES), .MAX_APPS(MAX_APPS), .WG_W(WG_W),
  .CNT_W(CNT_W), .ENT_W(ENT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
  .core_cnt(core_cnt), .cap_flat(cap_flat), .owner_map(owner_map)
);

// File: tb/sim_cpart_top.sv
module sim_cpart_top;
  localparam int CLK_P = 10;
  localparam int NC = 30;
  localparam int NA = 4;
  localparam int WW = 8;
  localparam int CW = 5;
  localparam int EW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       num_apps = '0;
  logic [NA*WW-1:0] wg_count = '0;
  logic             done, err;
  logic [NA*CW-1:0] core_cnt;
  logic [NC*EW-1:0] owner_map;

  int checks = 0;
  int errors = 0;
  int wv [NA];
  int ev [NA];
  int vals [5] = '{0, 3, 7, 12, 200};

  always #(CLK_P/2) clk = ~clk;

  cpart_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_apps(num_apps),
    .wg_count(wg_count), .done(done), .err(err),
    .core_cnt(core_cnt), .owner_map(owner_map)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Water-fill: largest level L with sum(min(cap,L)) <= NC, extras to lowest index.
  function automatic void calc(input int n);
    int c [NA];
    int best, s, r;
    best = 0;
    for (int i = 0; i < NA; i++) c[i] = (i < n) ? wv[i] : 0;
    for (int l = 0; l <= NC; l++) begin
      s = 0;
      for (int i = 0; i < NA; i++) s += (c[i] < l) ? c[i] : l;
      if (s <= NC) best = l;
    end
    s = 0;
    for (int i = 0; i < NA; i++) begin
      ev[i] = (c[i] < best) ? c[i] : best;
      s += ev[i];
    end
    r = NC - s;
    for (int i = 0; i < NA; i++) begin
      if (r > 0 && c[i] > best) begin
        ev[i]++;
        r--;
      end
    end
  endfunction

  task automatic drive(input int n);
    num_apps = n[2:0];
    for (int i = 0; i < NA; i++) wg_count[i*WW +: WW] = wv[i][WW-1:0];
  endtask

  task automatic wait_done();
    int cyc;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R1", int'(done), 1);
  endtask

  task automatic judge(input int n);
    bit bad;
    int act, cap, sumcap, total, mx, mn, k;
    logic [NC*EW-1:0] em;
    bad = (n == 0) || (n > NA);
    calc(n);
    if (bad) for (int i = 0; i < NA; i++) ev[i] = 0;
    chk(err == bad, "R7", int'(err), int'(bad));
    sumcap = 0; total = 0; mx = 0; mn = 1000;
    for (int i = 0; i < NA; i++) begin
      act = int'(core_cnt[i*CW +: CW]);
      cap = (i < n && !bad) ? wv[i] : 0;
      sumcap += cap;
      total += act;
      chk(act == ev[i], (i >= n) ? "R9" : "R4", act, ev[i]);
      chk(act <= cap, "R3", act, cap);
      if (act < cap) begin
        if (act > mx) mx = act;
        if (act < mn) mn = act;
      end
    end
    if (mn != 1000) chk(mx - mn <= 1, "R2", mx - mn, 1);
    chk(total == ((sumcap < NC) ? sumcap : NC), "R5", total, (sumcap < NC) ? sumcap : NC);
    em = '0;
    k = 0;
    for (int a = 0; a < NA; a++)
      for (int j = 0; j < ev[a]; j++) begin
        em[k*EW +: EW] = {1'b1, a[1:0]};
        k++;
      end
    checks++;
    if (owner_map !== em) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", "R6", owner_map, em);
    end
  endtask

  task automatic run(input int n);
    logic [NA*CW-1:0] sc;
    logic [NC*EW-1:0] sm;
    logic             se;
    @(negedge clk);
    drive(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R1", int'(done), 0);
    wait_done();
    judge(n);
    sc = core_cnt; sm = owner_map; se = err;
    num_apps = num_apps ^ 3'd5;
    wg_count = ~wg_count;
    repeat (3) @(negedge clk);
    checks++;
    if (core_cnt !== sc || owner_map !== sm || err !== se || done !== 1'b1) begin
      errors++;
      $display("FAIL %s actual=%h/%h expected=%h/%h", "R8", core_cnt, owner_map, sc, sm);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R1", int'(done), 0);
    chk(owner_map == '0 && core_cnt == '0, "R6", int'(core_cnt), 0);

    // Uncapped four-way split of 30: 8,8,7,7 (remainder to low indices).
    for (int i = 0; i < NA; i++) wv[i] = 200;
    run(4);
    // Pool exhausted exactly on the last active application: 10,10,10.
    run(3);
    // Caps summing below the pool: a round with no grant ends the scan.
    wv = '{3, 0, 7, 12};
    run(4);

    // Out-of-range application counts.
    run(0);
    run(5);
    run(7);

    // Restart while an allocation is under way.
    for (int i = 0; i < NA; i++) wv[i] = 200;
    @(negedge clk);
    drive(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    wv = '{3, 200, 0, 0};
    drive(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(int'(core_cnt[0 +: CW]) == 3 && int'(core_cnt[CW +: CW]) == 27, "R1",
        int'(core_cnt[CW +: CW]), 27);

    // Sweeps over work-group values for each valid application count.
    for (int a = 0; a < 5; a++) begin
      wv = '{vals[a], 0, 0, 0};
      run(1);
      for (int b = 0; b < 5; b++) begin
        wv = '{vals[a], vals[b], 0, 0};
        run(2);
        for (int c = 0; c < 5; c++) begin
          wv = '{vals[a], vals[b], vals[c], 99};
          run(3);
          for (int d = 0; d < 5; d++) begin
            wv = '{vals[a], vals[b], vals[c], vals[d]};
            run(4);
          end
        end
      end
    end
    finish_up();
  end
endmodule